// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is a counter/timer that serves a single processor. It is controlled through a small register port with 32-bit words and word addresses. An external mode input selects one of two personalities.

In counter mode the count climbs in steps of one prescaled tick. When it equals a programmable limit, the block sets a reached flag and raises a local interrupt. On the next tick the count goes back to zero. Software clears the flag and the interrupt by reading the limit word.

In user-timer mode the same two register words address the upper and lower halves of a 63-bit free-running counter. Software can start and stop this counter. When it reaches its maximum it sets the reached flag, but it never raises the interrupt.

The tick input is an enable pulse that comes from an external prescaler. Each tick adds one to the count at bit 9, so count bits 8:0 are always zero.

Top module: `proc_timer`

## Requirements
- R1: Each counted tick adds 0x200 to the count, and count bits 8:0 always read as zero.
- R2: In counter mode, word 1 reads as {reached, count[30:0]}. When a tick makes the count equal to the effective limit, reached and irq are set. The next tick returns the count to zero.
- R3: A limit of zero means free-run: the effective limit becomes 0x7FFFFE00, the count wraps there, and reaching it sets reached and irq.
- R4: In counter mode, a read of word 0 returns {0, limit[30:0]} and clears both reached and irq. If a tick reaches the limit in the same cycle, the tick wins and the flags stay set.
- R5: In counter mode, a write to word 0 stores wdata & 0x7FFFFE00 as the limit, zeroes the count and drops irq. A write to word 2 stores the limit the same way in either mode and leaves the count unchanged.
- R6: In user-timer mode, word 0 reads as {reached, count[62:32]} and word 1 reads as count[31:0]. A write to word 0 loads count[62:32] from wdata[30:0]. A write to word 1 loads count[31:0] from wdata with bits 8:0 cleared. Either write clears reached.
- R7: In user-timer mode, reaching 0x7FFFFFFFFFFFFE00 sets reached and leaves irq low. The next counted tick wraps the count to zero. irq stays low for as long as the block is in user-timer mode.
- R8: In user-timer mode, a write to word 3 with bit 0 equal to 1 starts the counter and with bit 0 equal to 0 stops it, and a stopped counter ignores ticks. Word 3 reads as the run bit in user-timer mode and as 1 in counter mode. In counter mode, writes to word 3 have no effect.
- R9: Entering user-timer mode stops the counter and drops irq. Leaving user-timer mode resumes counting. Both transitions keep the count value.
- R10: After reset the limit and count are zero, reached and irq are low, and the block counts freely in counter mode.
- R11: Reads of word 2 and of word addresses 4 to 7 return zero. Writes to addresses 4 to 7, and writes to word 1 in counter mode, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled count enable |
| user_mode | input | 1 | 1 selects user-timer mode |
| addr | input | 3 | Word address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects on word 0) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the current address |
| irq | output | 1 | Counter-mode interrupt |

## Verification
The bench targets the cycle that follows a limit hit. A design with an off-by-one compare would either skip the reached flag or produce periods of unequal length. The bench also drives a read of word 0 in the same cycle as the tick that reaches the limit. A design that let the read win would lose an interrupt.

For the 63-bit maximum and the 0x7FFFFE00 free-run wrap, the bench preloads counts through user-timer mode and then switches mode. A block that reset the count on a mode change, or raised the interrupt in user-timer mode, would show the wrong value or a stray irq.

Writes to word 3 in counter mode and writes to unused addresses are followed by read-back. This catches decoders that alias addresses.

// File: rtl/proc_timer.sv
module proc_timer #(
  parameter int ADDR_W   = 3,
  parameter int TICK_LSB = 9,
  parameter int CNT_W    = 63,
  parameter int LIM_W    = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              user_mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);

  localparam int HI_W = CNT_W - 32;
  localparam logic [CNT_W-1:0] STEP     = CNT_W'(1) << TICK_LSB;
  localparam logic [CNT_W-1:0] USR_TOP  = ~((CNT_W'(1) << TICK_LSB) - CNT_W'(1));
  localparam logic [LIM_W-1:0] FREE_TOP = ~((LIM_W'(1) << TICK_LSB) - LIM_W'(1));

  logic [CNT_W-1:0] cnt_q;
  logic [LIM_W-1:0] lim_q;
  logic             reached_q, irq_q, run_q, mode_q;

  logic             rising, falling, run_eff, advance, hit;
  logic [CNT_W-1:0] top, cnt_inc;
  logic [LIM_W-1:0] eff_lim;

  assign rising  = user_mode & ~mode_q;
  assign falling = ~user_mode & mode_q;
  assign run_eff = run_q & ~rising;
  assign eff_lim = (lim_q == '0) ? FREE_TOP : lim_q;
  assign top     = user_mode ? USR_TOP : CNT_W'(eff_lim);
  assign cnt_inc = (cnt_q >= top) ? '0 : cnt_q + STEP;
  assign advance = tick & (~user_mode | run_eff);
  assign hit     = advance & (cnt_inc == top);
  assign irq     = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      lim_q     <= '0;
      reached_q <= 1'b0;
      irq_q     <= 1'b0;
      run_q     <= 1'b1;
      mode_q    <= 1'b0;
    end else begin
      mode_q <= user_mode;
      if (advance) cnt_q <= cnt_inc;
      if (rising) begin
        run_q <= 1'b0;
        irq_q <= 1'b0;
      end else if (falling) begin
        run_q <= 1'b1;
      end
      if (rd_en && addr == ADDR_W'(0) && !user_mode) begin
        reached_q <= 1'b0;
        irq_q     <= 1'b0;
      end
      if (wr_en) begin
        case (addr)
          ADDR_W'(0): begin
            if (user_mode) begin
              cnt_q[CNT_W-1:32] <= wdata[HI_W-1:0];
              reached_q         <= 1'b0;
            end else begin
              lim_q <= wdata[LIM_W-1:0] & FREE_TOP;
              cnt_q <= '0;
              irq_q <= 1'b0;
            end
          end
          ADDR_W'(1): begin
            if (user_mode) begin
              cnt_q[31:0] <= {wdata[31:TICK_LSB], {TICK_LSB{1'b0}}};
              reached_q   <= 1'b0;
            end
          end
          ADDR_W'(2): lim_q <= wdata[LIM_W-1:0] & FREE_TOP;
          ADDR_W'(3): if (user_mode) run_q <= wdata[0];
          default: ;
        endcase
      end
      if (hit) begin
        reached_q <= 1'b1;
        if (!user_mode) irq_q <= 1'b1;
      end
    end
  end

  always_comb begin
    case (addr)
      ADDR_W'(0): rdata = user_mode ? {reached_q, cnt_q[CNT_W-1:32]} : {1'b0, lim_q};
      ADDR_W'(1): rdata = user_mode ? cnt_q[31:0] : {reached_q, cnt_q[LIM_W-1:0]};
      ADDR_W'(3): rdata = {31'b0, user_mode ? run_eff : 1'b1};
      default:    rdata = '0;
    endcase
  end

  assert_low_bits_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(1)) |-> rdata[TICK_LSB-1:0] == '0);

  assert_irq_with_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> reached_q);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(0) && !user_mode && !tick) |=> !irq);

  assert_write_restarts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(0) && !user_mode) |=> cnt_q == '0);

  assert_user_no_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && mode_q) |-> !irq);

  assert_stopped_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && mode_q && !run_q && !wr_en) |=> cnt_q == $past(cnt_q));

endmodule

// File: tb/proc_timer_tb.sv
module proc_timer_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0, user_mode = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;

  logic [62:0] m_cnt;
  logic [30:0] m_lim;
  logic        m_reached, m_irq, m_run, m_mode;

  localparam logic [62:0] USR_MAX = 63'h7FFF_FFFF_FFFF_FE00;
  localparam logic [30:0] FREE    = 31'h7FFF_FE00;

  proc_timer u_dut (.clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
    .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [62:0] top_of();
    if (m_mode) return USR_MAX;
    return {32'b0, (m_lim == '0) ? FREE : m_lim};
  endfunction

  function automatic logic [31:0] exp_read(input int a);
    case (a)
      0: return m_mode ? {m_reached, m_cnt[62:32]} : {1'b0, m_lim};
      1: return m_mode ? m_cnt[31:0] : {m_reached, m_cnt[30:0]};
      3: return {31'b0, m_mode ? m_run : 1'b1};
      default: return 32'b0;
    endcase
  endfunction

  function automatic void model_tick();
    logic [62:0] t;
    if (m_mode && !m_run) return;
    t = top_of();
    m_cnt = (m_cnt >= t) ? '0 : m_cnt + 63'h200;
    if (m_cnt == t) begin
      m_reached = 1'b1;
      if (!m_mode) m_irq = 1'b1;
    end
  endfunction

  task automatic ticks(input int n, input string tag);
    @(negedge clk); tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      model_tick();
      @(negedge clk);
    end
    tick = 1'b0;
    chk({tag, " irq"}, irq, m_irq);
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a[2:0]; wdata = d;
    case (a)
      0: if (m_mode) begin m_cnt[62:32] = d[30:0]; m_reached = 1'b0; end
         else begin m_lim = d[30:0] & FREE; m_cnt = '0; m_irq = 1'b0; end
      1: if (m_mode) begin m_cnt[31:0] = d & 32'hFFFF_FE00; m_reached = 1'b0; end
      2: m_lim = d[30:0] & FREE;
      3: if (m_mode) m_run = d[0];
      default: ;
    endcase
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, input string tag);
    logic [31:0] got, exp;
    @(negedge clk); rd_en = 1'b1; addr = a[2:0];
    #1 got = rdata;
    exp = exp_read(a);
    if (a == 0 && !m_mode) begin m_reached = 1'b0; m_irq = 1'b0; end
    @(negedge clk); rd_en = 1'b0;
    chk(tag, got, exp);
    chk({tag, " irq"}, irq, m_irq);
  endtask

  task automatic set_mode(input logic v);
    @(negedge clk); user_mode = v;
    if (v && !m_mode) begin m_run = 1'b0; m_irq = 1'b0; end
    if (!v && m_mode) m_run = 1'b1;
    m_mode = v;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    m_cnt = '0; m_lim = '0; m_reached = 1'b0; m_irq = 1'b0; m_run = 1'b1; m_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk("R10 irq after reset", irq, 1'b0);
    rd(0, "R10 limit after reset");
    rd(1, "R10 count after reset");
    rd(3, "R10 status after reset");
    ticks(3, "R10");
    rd(1, "R1 count after 3 ticks");

    wr(0, 32'hFFFF_FFFF);
    rd(0, "R5 limit masked");
    wr(0, 32'h0000_0600);
    ticks(2, "R2 before hit");
    rd(1, "R2 before hit");
    ticks(1, "R2 hit irq");
    rd(1, "R2 reached in count");
    ticks(1, "R2 wrap");
    rd(1, "R2 wrapped to zero");
    rd(0, "R4 read clears");
    ticks(2, "R2 second period");
    ticks(1, "R2 second hit");

    // read of word 0 in the same cycle as the hitting tick: flags stay
    wr(0, 32'h0000_0400);
    ticks(1, "R4 setup");
    @(negedge clk); tick = 1'b1; rd_en = 1'b1; addr = 3'd0;
    #1 chk("R4 read value during hit", rdata, {1'b0, m_lim});
    model_tick();
    @(negedge clk); tick = 1'b0; rd_en = 1'b0;
    chk("R4 tick wins irq", irq, 1'b1);
    rd(1, "R4 tick wins reached");

    ticks(1, "R5 prep");
    wr(2, 32'h0000_1000);
    rd(1, "R5 word2 keeps count");
    rd(0, "R5 word2 limit");

    wr(3, 32'h0);
    ticks(2, "R8 counter ignores stop");
    rd(3, "R8 status in counter mode");
    rd(1, "R8 still counting");

    wr(5, 32'hFFFF_FFFF);
    wr(1, 32'h0001_0000);
    rd(1, "R11 count untouched");
    rd(0, "R11 limit untouched");
    rd(5, "R11 undefined read");
    rd(2, "R11 word2 reads zero");

    ticks(1, "R9 pre");
    set_mode(1'b1);
    chk("R9 irq dropped", irq, 1'b0);
    rd(3, "R9 stopped on entry");
    ticks(3, "R8 stopped ignores ticks");
    rd(1, "R9 count kept");
    wr(0, 32'h7FFF_FFFF);
    wr(1, 32'hFFFF_FDFF);
    rd(0, "R6 upper half");
    rd(1, "R6 lower half masked");
    wr(3, 32'h1);
    rd(3, "R8 running");
    ticks(1, "R7 max no irq");
    rd(0, "R7 reached at max");
    ticks(1, "R7 wrap");
    rd(1, "R7 wrapped low");
    rd(0, "R7 wrapped high");
    wr(1, 32'h0000_0200);
    rd(0, "R6 write clears reached");
    wr(3, 32'h0);
    ticks(2, "R8 stop");
    rd(1, "R8 stopped count");

    wr(0, 32'h0);
    wr(1, 32'h7FFF_F000);
    wr(2, 32'h0);
    set_mode(1'b0);
    ticks(6, "R3 before free top");
    ticks(1, "R3 free top irq");
    rd(1, "R3 free top reached");
    ticks(1, "R3 free wrap");
    rd(1, "R3 wrapped");

    for (int it = 0; it < 400; it++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0: wr(0, ($urandom_range(0, 6) << 9) | ($urandom & 32'h1FF));
        1: wr(2, $urandom_range(0, 6) << 9);
        2: wr(1, m_mode ? ($urandom_range(0, 7) << 9) : $urandom);
        3: wr(3, $urandom_range(0, 1));
        4: rd(0, "R4 R6 random word0");
        5: rd(1, "R2 R6 random word1");
        6: rd(3, "R8 random status");
        7: set_mode(($urandom_range(0, 5) == 0) ? ~m_mode : m_mode);
        default: ticks($urandom_range(1, 6), "R2 R7 random ticks");
      endcase
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule